// File: doc/BRIEF.md
# Three-Level Page Walk Translator

This block turns a 64-bit virtual address into a 56-bit physical address by walking a three-level page-table tree held in memory. A request carries the virtual address and an access kind (read, write or execute). The walker latches the root table's physical page number, fetches one 64-bit entry per level through a single-outstanding memory read port, and inspects each entry. A pointer entry leads to the next level down. A leaf entry at the bottom level is checked against the access kind, and the walk ends with either a physical address or a page fault.

The walker handles one translation at a time. It raises `req_ready` only while idle and presents its result on `resp_valid` for a single cycle. Every table is 4096 bytes and holds 512 entries of 8 bytes. The entry address for a level is the table's page number shifted left by 12, plus eight times the 9-bit index taken from the virtual address for that level.

Top module: `vat_walker`

## Requirements
- R1: Virtual address bits 63:39 have no effect on the walk or the result.
- R2: On a successful translation, `resp_paddr[11:0]` equals the request's virtual address bits 11:0.
- R3: The walk reads the root table first, using index VA[38:30], then the middle level using VA[29:21], then the bottom level using VA[20:12]. Each read address is (table page number << 12) + index*8, and a successful translation makes exactly three reads.
- R4: On success, `resp_paddr[55:12]` equals bits 53:10 of the bottom-level entry, and entry bits 63:54 are ignored.
- R5: An entry whose valid bit (bit 0) is clear ends the walk at that level with `resp_fault`=1 and `resp_paddr`=0.
- R6: Access kinds are encoded 00 read, 01 write, 10 execute. The leaf must have the matching flag set (R in bit 1, W in bit 2, X in bit 3), or the walk faults. Kind 11 always faults.
- R7: A valid entry with W set and R clear faults, whatever the access kind.
- R8: A valid entry with R, W and X all clear is a pointer. A pointer at the bottom level faults, and a leaf at the root or middle level faults after that level's read.
- R9: `req_ready` is high only while idle. A request is taken only when `req_ready` is high. A request presented while busy is ignored. `resp_valid` stays high for exactly one cycle per accepted request.
- R10: `mem_req` is a one-cycle pulse, and no new read is issued until the previous one has returned on `mem_rvalid`.
- R11: After reset, `req_ready` is 1 and both `resp_valid` and `mem_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request strobe |
| req_ready | output | 1 | Walker idle, request will be taken |
| req_vaddr | input | 64 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| root_ppn | input | 44 | Physical page number of the root table, sampled when a request is taken |
| mem_req | output | 1 | Entry read request pulse |
| mem_addr | output | 56 | Physical byte address of the entry |
| mem_rvalid | input | 1 | Entry read data valid |
| mem_rdata | input | 64 | Entry read data |
| resp_valid | output | 1 | Result valid, one cycle |
| resp_fault | output | 1 | Page fault, qualified by resp_valid |
| resp_paddr | output | 56 | Physical address, zero on fault |

## Verification
A wrong level counter or a wrong index selection makes the walker fetch an entry from the wrong slot. That shows up within the walk as a `mem_addr` that differs from the expected entry address, and at the response as a wrong read count, a wrong physical page or a spurious fault. A decode error shows only at the response, in the same cycle the leaf is judged: a fault and a grant change places. A state machine stuck outside idle holds `req_ready` low and never raises `resp_valid`. The bench therefore checks the read count, the read addresses, the one-cycle response pulse and the idle handshake, not only the final address.

// File: rtl/vat_pkg.sv
package vat_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_WAIT,
      ST_CHECK,
      ST_DONE,
      ST_FAULT
   } walk_state_t;

   // outcome of inspecting one fetched entry
   typedef enum logic [1:0] {
      PC_FAULT,
      PC_DESCEND,
      PC_GRANT
   } pte_class_t;

   localparam logic [1:0] ACC_READ  = 2'b00;
   localparam logic [1:0] ACC_WRITE = 2'b01;
   localparam logic [1:0] ACC_EXEC  = 2'b10;

   localparam int FLAG_V = 0;
   localparam int FLAG_R = 1;
   localparam int FLAG_W = 2;
   localparam int FLAG_X = 3;

endpackage

// File: rtl/vat_idx_sel.sv
module vat_idx_sel #(
   parameter int VA_W     = 39,
   parameter int PA_W     = 56,
   parameter int PPN_W    = 44,
   parameter int OFF_W    = 12,
   parameter int IDX_W    = 9,
   parameter int LEVELS   = 3,
   parameter int ENT_LOG2 = 3,
   localparam int LVL_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
   input  logic [VA_W-1:0]  vaddr,
   input  logic [LVL_W-1:0] level,
   input  logic [PPN_W-1:0] table_ppn,
   output logic [PA_W-1:0]  entry_addr
);

   logic [IDX_W-1:0] idx_by_lvl [LEVELS];
   logic [IDX_W-1:0] idx;

   generate
      for (genvar g = 0; g < LEVELS; g++) begin : g_slice
         assign idx_by_lvl[g] = vaddr[OFF_W + g*IDX_W +: IDX_W];
      end
   endgenerate

   always_comb begin
      idx = '0;
      for (int k = 0; k < LEVELS; k++) begin
         if (level == LVL_W'(k)) idx = idx_by_lvl[k];
      end
   end

   assign entry_addr = (PA_W'(table_ppn) << OFF_W) + (PA_W'(idx) << ENT_LOG2);

endmodule

// File: rtl/vat_pte_decode.sv
module vat_pte_decode
   import vat_pkg::*;
#(
   parameter int PTE_W   = 64,
   parameter int PPN_W   = 44,
   parameter int PPN_LSB = 10
) (
   input  logic [PTE_W-1:0] pte,
   input  logic [1:0]       kind,
   input  logic             last_level,
   output pte_class_t       cls,
   output logic [PPN_W-1:0] next_ppn
);

   logic v, r, w, x;
   logic unused_pte_bits;

   assign v = pte[FLAG_V];
   assign r = pte[FLAG_R];
   assign w = pte[FLAG_W];
   assign x = pte[FLAG_X];
   assign next_ppn = pte[PPN_LSB +: PPN_W];
   assign unused_pte_bits = ^{pte[PTE_W-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:FLAG_X+1]};

   always_comb begin
      cls = PC_FAULT;
      if (!v || (w && !r)) begin
         cls = PC_FAULT;
      end else if (!r && !x) begin
         cls = last_level ? PC_FAULT : PC_DESCEND;
      end else if (last_level) begin
         unique case (kind)
            ACC_READ:  cls = r ? PC_GRANT : PC_FAULT;
            ACC_WRITE: cls = w ? PC_GRANT : PC_FAULT;
            ACC_EXEC:  cls = x ? PC_GRANT : PC_FAULT;
            default:   cls = PC_FAULT;
         endcase
      end
   end

endmodule

// File: rtl/vat_walker.sv
module vat_walker
   import vat_pkg::*;
#(
   parameter int XLEN    = 64,
   parameter int VA_W    = 39,
   parameter int PA_W    = 56,
   parameter int PPN_W   = 44,
   parameter int OFF_W   = 12,
   parameter int IDX_W   = 9,
   parameter int LEVELS  = 3,
   parameter int PTE_W   = 64,
   parameter int PPN_LSB = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [XLEN-1:0]  req_vaddr,
   input  logic [1:0]       req_kind,
   input  logic [PPN_W-1:0] root_ppn,
   output logic             mem_req,
   output logic [PA_W-1:0]  mem_addr,
   input  logic             mem_rvalid,
   input  logic [PTE_W-1:0] mem_rdata,
   output logic             resp_valid,
   output logic             resp_fault,
   output logic [PA_W-1:0]  resp_paddr
);

   localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
   localparam int ENT_LOG2 = $clog2(PTE_W / 8);

   generate
      if (VA_W != OFF_W + LEVELS*IDX_W) begin : g_bad_va
         $error("virtual width must equal offset plus all level indices");
      end
      if (PA_W != PPN_W + OFF_W) begin : g_bad_pa
         $error("physical width must equal page number plus offset");
      end
      if (PPN_LSB + PPN_W > PTE_W || PPN_LSB <= FLAG_X + 1) begin : g_bad_pte
         $error("page number field does not fit the entry");
      end
      if (IDX_W + ENT_LOG2 != OFF_W) begin : g_bad_tbl
         $error("a table must fill exactly one page");
      end
      if (XLEN < VA_W + 1) begin : g_bad_xlen
         $error("request address narrower than the translated field");
      end
   endgenerate

   walk_state_t      state;
   logic [VA_W-1:0]  va_q;
   logic [1:0]       kind_q;
   logic [LVL_W-1:0] level_q;
   logic [PPN_W-1:0] tbl_q;
   logic [PTE_W-1:0] pte_q;
   logic [PA_W-1:0]  paddr_q;
   pte_class_t       cls;
   logic [PPN_W-1:0] next_ppn;
   logic             unused_va_hi;

   assign unused_va_hi = ^req_vaddr[XLEN-1:VA_W];

   vat_idx_sel #(
      .VA_W(VA_W), .PA_W(PA_W), .PPN_W(PPN_W), .OFF_W(OFF_W),
      .IDX_W(IDX_W), .LEVELS(LEVELS), .ENT_LOG2(ENT_LOG2)
   ) i_idx_sel (
      .vaddr     (va_q),
      .level     (level_q),
      .table_ppn (tbl_q),
      .entry_addr(mem_addr)
   );

   vat_pte_decode #(
      .PTE_W(PTE_W), .PPN_W(PPN_W), .PPN_LSB(PPN_LSB)
   ) i_pte_decode (
      .pte       (pte_q),
      .kind      (kind_q),
      .last_level(level_q == '0),
      .cls       (cls),
      .next_ppn  (next_ppn)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         va_q    <= '0;
         kind_q  <= ACC_READ;
         level_q <= '0;
         tbl_q   <= '0;
         pte_q   <= '0;
         paddr_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (req_valid) begin
               va_q    <= req_vaddr[VA_W-1:0];
               kind_q  <= req_kind;
               level_q <= LVL_W'(LEVELS - 1);
               tbl_q   <= root_ppn;
               state   <= ST_FETCH;
            end
            ST_FETCH: state <= ST_WAIT;
            ST_WAIT: if (mem_rvalid) begin
               pte_q <= mem_rdata;
               state <= ST_CHECK;
            end
            ST_CHECK: begin
               unique case (cls)
                  PC_DESCEND: begin
                     tbl_q   <= next_ppn;
                     level_q <= level_q - 1'b1;
                     state   <= ST_FETCH;
                  end
                  PC_GRANT: begin
                     paddr_q <= {next_ppn, va_q[OFF_W-1:0]};
                     state   <= ST_DONE;
                  end
                  default: state <= ST_FAULT;
               endcase
            end
            ST_DONE, ST_FAULT: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == ST_IDLE);
   assign mem_req    = (state == ST_FETCH);
   assign resp_valid = (state == ST_DONE) || (state == ST_FAULT);
   assign resp_fault = (state == ST_FAULT);
   assign resp_paddr = (state == ST_DONE) ? paddr_q : '0;

   // R10: a read pulse is never followed directly by another
   a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |=> !mem_req);

   // R9: the result is presented for one cycle only
   a_r9_one_cycle_resp: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   // R9 and R3: a taken request closes the handshake and starts the root read
   a_r9_accept_starts_walk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!req_ready && mem_req));

   // R2: the page offset reaches the result untouched
   a_r2_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_fault) |-> (resp_paddr[OFF_W-1:0] == va_q[OFF_W-1:0]));

   // R7: write-without-read entries never grant
   a_r7_reserved_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && pte_q[FLAG_V] && pte_q[FLAG_W] && !pte_q[FLAG_R])
      |=> resp_fault);

   // R8: a leaf above the bottom level never grants
   a_r8_high_leaf_faults: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_CHECK && level_q != '0 && pte_q[FLAG_V] && (pte_q[FLAG_R] || pte_q[FLAG_X]))
      |=> resp_fault);

   // R5: faults carry a zero address
   a_r5_fault_zero_addr: assert property (@(posedge clk) disable iff (!rst_n)
      resp_fault |-> (resp_paddr == '0));

endmodule

// File: tb/test_vat_walker.sv
module test_vat_walker;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [63:0] req_vaddr = '0;
   logic [1:0]  req_kind = 2'b00;
   logic [43:0] root_ppn = 44'h100;
   logic        mem_req;
   logic [55:0] mem_addr;
   logic        mem_rvalid = 1'b0;
   logic [63:0] mem_rdata = '0;
   logic        resp_valid;
   logic        resp_fault;
   logic [55:0] resp_paddr;

   int checks = 0;
   int fails  = 0;
   int nreads = 0;
   int cycles = 0;
   logic [55:0] alog [8];

   always #2.5 clk = ~clk;

   vat_walker i_vat_walker (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready),
      .req_vaddr(req_vaddr), .req_kind(req_kind), .root_ppn(root_ppn),
      .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
      .resp_valid(resp_valid), .resp_fault(resp_fault), .resp_paddr(resp_paddr)
   );

   // sparse memory, one-cycle read latency
   logic [63:0] mem [logic [55:0]];

   function automatic logic [63:0] rd(input logic [55:0] a);
      return mem.exists(a) ? mem[a] : 64'h0;
   endfunction

   always @(posedge clk) begin
      mem_rvalid <= mem_req;
      if (mem_req) begin
         mem_rdata        <= rd(mem_addr);
         alog[nreads % 8] <= mem_addr;
         nreads           <= nreads + 1;
      end
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   function automatic logic [63:0] mkpte(input logic [43:0] ppn, input logic [3:0] fl,
                                         input logic [9:0] hi);
      return {hi, ppn, 6'b0, fl};
   endfunction

   task automatic put(input logic [43:0] tbl, input int idx, input logic [63:0] e);
      mem[{tbl, 12'h0} + 56'(idx * 8)] = e;
   endtask

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xlate(input logic [63:0] va, input logic [1:0] kind, output logic flt,
                        output logic [55:0] pa, output int nrd);
      int start;
      int lat;
      start = nreads;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = va; req_kind = kind;
      @(negedge clk);
      req_valid = 1'b0;
      lat = 0;
      while (!resp_valid && lat < 200) begin
         @(negedge clk);
         lat++;
      end
      flt = resp_fault; pa = resp_paddr; nrd = nreads - start;
      chk(lat < 200, "R9 response arrives", 64'(lat), 64'd200);
      @(negedge clk);
      chk(!resp_valid, "R9 response lasts one cycle", 64'(resp_valid), 64'd0);
   endtask

   typedef struct packed {
      logic [8:0]  v2, v1, v0;
      logic [11:0] off;
      logic [24:0] hi;
      logic [1:0]  kind;
      logic        fault;
      logic [43:0] ppn;
      logic [3:0]  reads;
      logic [3:0]  tag;
   } vec_t;

   localparam vec_t VECS [16] = '{
      '{9'd1, 9'd2, 9'd3, 12'h0AB, 25'h0,       2'd0, 1'b0, 44'h0ABCDE12345, 4'd3, 4'd4}, // R4 read grant
      '{9'd1, 9'd2, 9'd3, 12'hFFF, 25'h1FFFFFF, 2'd1, 1'b0, 44'h0ABCDE12345, 4'd3, 4'd1}, // R1 high bits
      '{9'd1, 9'd2, 9'd3, 12'h000, 25'h0,       2'd2, 1'b1, 44'h0,           4'd3, 4'd6}, // R6 no X
      '{9'd1, 9'd2, 9'd4, 12'h123, 25'h0,       2'd2, 1'b0, 44'h777,         4'd3, 4'd6}, // R6 exec grant
      '{9'd1, 9'd2, 9'd4, 12'h123, 25'h0,       2'd1, 1'b1, 44'h0,           4'd3, 4'd6}, // R6 no W
      '{9'd1, 9'd2, 9'd5, 12'h000, 25'h0,       2'd0, 1'b1, 44'h0,           4'd3, 4'd5}, // R5 bottom invalid
      '{9'd1, 9'd2, 9'd6, 12'h000, 25'h0,       2'd1, 1'b1, 44'h0,           4'd3, 4'd7}, // R7 W without R
      '{9'd1, 9'd2, 9'd7, 12'h000, 25'h0,       2'd0, 1'b1, 44'h0,           4'd3, 4'd8}, // R8 pointer at bottom
      '{9'd1, 9'd2, 9'd8, 12'h800, 25'h0,       2'd2, 1'b0, 44'h55,          4'd3, 4'd6}, // R6 exec-only
      '{9'd1, 9'd2, 9'd8, 12'h000, 25'h0,       2'd0, 1'b1, 44'h0,           4'd3, 4'd6}, // R6 read of exec-only
      '{9'd1, 9'd2, 9'd9, 12'h010, 25'h0AAAAAA, 2'd0, 1'b0, 44'h123,         4'd3, 4'd4}, // R4 upper entry bits
      '{9'd2, 9'd0, 9'd0, 12'h000, 25'h0,       2'd0, 1'b1, 44'h0,           4'd1, 4'd8}, // R8 root leaf
      '{9'd3, 9'd0, 9'd0, 12'h000, 25'h0,       2'd0, 1'b1, 44'h0,           4'd2, 4'd8}, // R8 middle leaf
      '{9'd4, 9'd0, 9'd0, 12'h000, 25'h0,       2'd0, 1'b1, 44'h0,           4'd1, 4'd5}, // R5 root invalid
      '{9'd1, 9'd2, 9'd3, 12'h000, 25'h0,       2'd3, 1'b1, 44'h0,           4'd3, 4'd6}, // R6 kind 11
      '{9'd1, 9'd3, 9'd0, 12'h000, 25'h0,       2'd0, 1'b1, 44'h0,           4'd2, 4'd5}  // R5 middle invalid
   };

   initial begin
      logic        flt;
      logic [55:0] pa;
      int          nrd;
      int          start;

      put(44'h100, 1, mkpte(44'h101, 4'b0001, 10'h0));
      put(44'h100, 2, mkpte(44'h200, 4'b0011, 10'h0));
      put(44'h100, 3, mkpte(44'h103, 4'b0001, 10'h0));
      put(44'h101, 2, mkpte(44'h102, 4'b0001, 10'h0));
      put(44'h102, 3, mkpte(44'h0ABCDE12345, 4'b0111, 10'h0));
      put(44'h102, 4, mkpte(44'h777, 4'b1011, 10'h0));
      put(44'h102, 5, mkpte(44'h999, 4'b0110, 10'h0));
      put(44'h102, 6, mkpte(44'h010, 4'b0101, 10'h0));
      put(44'h102, 7, mkpte(44'h103, 4'b0001, 10'h0));
      put(44'h102, 8, mkpte(44'h055, 4'b1001, 10'h0));
      put(44'h102, 9, mkpte(44'h123, 4'b1111, 10'h3FF));
      put(44'h103, 0, mkpte(44'h300, 4'b0111, 10'h0));

      // R11: reset state
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1, "R11 ready in reset", 64'(req_ready), 64'd1);
      chk(resp_valid == 1'b0, "R11 no response in reset", 64'(resp_valid), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready && !resp_valid && !mem_req, "R11 idle after reset",
          {61'd0, req_ready, resp_valid, mem_req}, 64'd4);

      // vector table
      for (int i = 0; i < 16; i++) begin
         vec_t  v;
         logic [63:0] va;
         logic [55:0] exp_pa;
         v = VECS[i];
         va = {v.hi, v.v2, v.v1, v.v0, v.off};
         exp_pa = v.fault ? 56'h0 : {v.ppn, v.off};
         xlate(va, v.kind, flt, pa, nrd);
         chk(flt == v.fault, $sformatf("R%0d vec %0d fault", v.tag, i), 64'(flt), 64'(v.fault));
         chk(pa == exp_pa, $sformatf("R%0d vec %0d paddr", v.tag, i), 64'(pa), 64'(exp_pa));
         chk(nrd == int'(v.reads), $sformatf("R10 vec %0d read count", i), 64'(nrd), 64'(v.reads));
      end

      // R3: read addresses in walk order
      start = nreads;
      xlate({25'h0, 9'd1, 9'd2, 9'd3, 12'h0}, 2'b00, flt, pa, nrd);
      chk(alog[(start + 0) % 8] == 56'h100008, "R3 root entry address",
          64'(alog[(start + 0) % 8]), 64'h100008);
      chk(alog[(start + 1) % 8] == 56'h101010, "R3 middle entry address",
          64'(alog[(start + 1) % 8]), 64'h101010);
      chk(alog[(start + 2) % 8] == 56'h102018, "R3 bottom entry address",
          64'(alog[(start + 2) % 8]), 64'h102018);

      // R9: request held while busy is ignored
      start = nreads;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {25'h0, 9'd1, 9'd2, 9'd4, 12'h321}; req_kind = 2'b00;
      @(negedge clk);
      req_vaddr = {25'h0, 9'd4, 9'd0, 9'd0, 12'h0}; req_kind = 2'b01;
      for (int k = 0; k < 5; k++) begin
         chk(!req_ready, "R9 ready low while busy", 64'(req_ready), 64'd0);
         @(negedge clk);
      end
      req_valid = 1'b0;
      for (int k = 0; k < 20 && !resp_valid; k++) @(negedge clk);
      chk(resp_valid && !resp_fault && resp_paddr == {44'h777, 12'h321},
          "R9 busy request ignored", 64'(resp_paddr), 64'({44'h777, 12'h321}));
      begin
         int extra;
         extra = 0;
         @(negedge clk);
         for (int k = 0; k < 20; k++) begin
            if (resp_valid) extra++;
            @(negedge clk);
         end
         chk(extra == 0, "R9 no second response", 64'(extra), 64'd0);
      end
      chk(nreads - start == 3, "R10 reads for one walk", 64'(nreads - start), 64'd3);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule